// File: doc/BRIEF.md
# Time-Multiplexed Vector Lane Sequencer

This block carries out one integer vector operation of programmable length on a small, fixed set of physical ALU lanes. A start strobe latches the element count and the operation. The sequencer then walks the vector in groups of `LANES` elements, one group per clock. While a group is being issued, the block presents the index of its first element. The caller answers combinationally with the operands of that group, one element per lane. Each group's results come back one cycle later, registered, with a valid strobe, a per-lane enable mask and the index of the group's first element.

Element i always travels on lane (i mod LANES) during pass (i div LANES). Results therefore leave in ascending element order, and a consumer that walks the enabled lanes in lane order sees the same element stream for any lane count. When the element count is not a multiple of the lane count, the upper lanes of the last group stay disabled and their result slots read zero. A length of one is an ordinary scalar operation on lane 0. A length of zero finishes at once and produces no results. A done pulse marks completion.

Top module: `vls_lane_seq`

## Requirements
- R1: While busy, `elem_idx_o` names the first element of the group being issued. Lane l operates on element `elem_idx_o + l`. That group's results appear in the next cycle with `res_valid_o` high and `res_idx_o` equal to the issued `elem_idx_o`.
- R2: Operation codes on `opcode_i`: 0 = a+b, 1 = a-b, 2 = a AND b, 3 = a OR b, 4 = a XOR b. All results are 32-bit with wraparound.
- R3: A vector of length L > 0 takes ceil(L/LANES) consecutive busy cycles. `elem_idx_o` steps 0, LANES, 2*LANES, and so on.
- R4: In each result group, lane l is enabled (bit l of `lane_en_o`) exactly when element `res_idx_o + l` is below L. Disabled lanes output zero, and lanes are enabled contiguously from lane 0.
- R5: With L = 1 the operation runs as a scalar: one result group, with only lane 0 enabled.
- R6: With L = 0, `done_o` is high in the cycle after the start is accepted, `busy_o` stays low, and no result group is emitted.
- R7: A start strobe while `busy_o` is high has no effect. The running sequence keeps its length, operation and element order.
- R8: `done_o` is high in the same cycle as the final result group, `busy_o` is low in that cycle, and `done_o` is low otherwise unless another start arrives.
- R9: After reset, `busy_o`, `res_valid_o`, `done_o`, `lane_en_o` and `res_o` are all zero.
- R10: Operation codes 5 to 7 give zero on every enabled lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| vlen_i | input | LEN_W | Number of elements |
| opcode_i | input | 3 | Operation code |
| busy_o | output | 1 | A group is being issued this cycle |
| elem_idx_o | output | LEN_W | First element of the group being issued |
| a_i | input | LANES*DATA_W | First operands, lane l in slice l |
| b_i | input | LANES*DATA_W | Second operands, lane l in slice l |
| res_valid_o | output | 1 | Result group valid |
| res_idx_o | output | LEN_W | First element of the result group |
| lane_en_o | output | LANES | Per-lane result enable |
| res_o | output | LANES*DATA_W | Per-lane results |
| done_o | output | 1 | Operation complete |

## Verification
The bound checker tests the following on every cycle:
- the issue index steps by the lane count on each busy cycle, which shows a start during busy cannot restart the sequence;
- each result group carries the index that was issued one cycle earlier;
- enable masks are contiguous and nonzero whenever results are valid;
- a partial group is always the final one, and done never coincides with busy.

The arithmetic, the exact lane mask for each length, the pass count, the scalar and zero-length cases, and the treatment of unused operation codes can only be shown by the bench. It compares every lane of every group against its own model over random and directed lengths and operations.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int unsigned OP_W = 3;
  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4
  } vls_op_e;
endpackage

// File: rtl/vls_lane_alu.sv
module vls_lane_alu #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                     en_i,
  input  logic [vls_pkg::OP_W-1:0] op_i,
  input  logic [DATA_W-1:0]        a_i,
  input  logic [DATA_W-1:0]        b_i,
  output logic [DATA_W-1:0]        y_o
);
  import vls_pkg::*;

  always_comb begin
    y_o = '0;
    if (en_i) begin
      case (op_i)
        OP_ADD:  y_o = a_i + b_i;
        OP_SUB:  y_o = a_i - b_i;
        OP_AND:  y_o = a_i & b_i;
        OP_OR:   y_o = a_i | b_i;
        OP_XOR:  y_o = a_i ^ b_i;
        default: y_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/vls_pass_ctrl.sv
module vls_pass_ctrl #(
  parameter int unsigned LANES = 4,
  parameter int unsigned LEN_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] vlen_i,
  output logic             busy_o,
  output logic             accept_o,
  output logic             zero_done_o,
  output logic             last_o,
  output logic [LEN_W-1:0] base_o,
  output logic [LANES-1:0] mask_o
);
  localparam int unsigned CNT_W = LEN_W + 1;

  logic             busy_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] base_q;
  logic [CNT_W-1:0] rem_w;

  assign accept_o    = start_i && !busy_q;
  assign zero_done_o = accept_o && (vlen_i == '0);
  assign rem_w       = {1'b0, len_q} - {1'b0, base_q};
  assign last_o      = busy_q && (({1'b0, base_q} + CNT_W'(LANES)) >= {1'b0, len_q});
  assign busy_o      = busy_q;
  assign base_o      = base_q;

  // lane l live while at least l+1 elements remain
  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign mask_o[l] = busy_q && (rem_w > CNT_W'(l));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      len_q  <= '0;
      base_q <= '0;
    end else if (accept_o) begin
      if (vlen_i != '0) begin
        busy_q <= 1'b1;
        len_q  <= vlen_i;
        base_q <= '0;
      end
    end else if (busy_q) begin
      if (last_o) busy_q <= 1'b0;
      else        base_q <= base_q + LEN_W'(LANES);
    end
  end
endmodule

// File: rtl/vls_lane_seq.sv
module vls_lane_seq #(
  parameter int unsigned LANES   = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned MAX_LEN = 31,
  localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1),
  localparam int unsigned BUS_W  = LANES * DATA_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [LEN_W-1:0]         vlen_i,
  input  logic [vls_pkg::OP_W-1:0] opcode_i,
  output logic                     busy_o,
  output logic [LEN_W-1:0]         elem_idx_o,
  input  logic [BUS_W-1:0]         a_i,
  input  logic [BUS_W-1:0]         b_i,
  output logic                     res_valid_o,
  output logic [LEN_W-1:0]         res_idx_o,
  output logic [LANES-1:0]         lane_en_o,
  output logic [BUS_W-1:0]         res_o,
  output logic                     done_o
);
  logic                     accept_w, zero_done_w, last_w, busy_w;
  logic [LEN_W-1:0]         base_w;
  logic [LANES-1:0]         mask_w;
  logic [BUS_W-1:0]         alu_w;
  logic [vls_pkg::OP_W-1:0] op_q;

  vls_pass_ctrl #(.LANES(LANES), .LEN_W(LEN_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .vlen_i      (vlen_i),
    .busy_o      (busy_w),
    .accept_o    (accept_w),
    .zero_done_o (zero_done_w),
    .last_o      (last_w),
    .base_o      (base_w),
    .mask_o      (mask_w)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    vls_lane_alu #(.DATA_W(DATA_W)) u_alu (
      .en_i (mask_w[l]),
      .op_i (op_q),
      .a_i  (a_i[l*DATA_W +: DATA_W]),
      .b_i  (b_i[l*DATA_W +: DATA_W]),
      .y_o  (alu_w[l*DATA_W +: DATA_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q        <= '0;
      res_valid_o <= 1'b0;
      res_idx_o   <= '0;
      lane_en_o   <= '0;
      res_o       <= '0;
      done_o      <= 1'b0;
    end else begin
      if (accept_w) op_q <= opcode_i;
      res_valid_o <= busy_w;
      res_idx_o   <= base_w;
      lane_en_o   <= mask_w;
      res_o       <= alu_w;
      done_o      <= zero_done_w || last_w;
    end
  end

  assign busy_o     = busy_w;
  assign elem_idx_o = base_w;
endmodule

// File: rtl/vls_lane_seq_chk.sv
module vls_lane_seq_chk #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 5
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    busy_o,
  input logic [LEN_W-1:0]        elem_idx_o,
  input logic                    res_valid_o,
  input logic [LEN_W-1:0]        res_idx_o,
  input logic [LANES-1:0]        lane_en_o,
  input logic [LANES*DATA_W-1:0] res_o,
  input logic                    done_o
);
  assert_idx_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> (elem_idx_o == $past(elem_idx_o) + LEN_W'(LANES)));

  // R7: a restart while busy would break the step above
  assert_no_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> (elem_idx_o != '0));

  assert_res_idx_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && $past(rst_ni)) |-> (res_idx_o == $past(elem_idx_o)));

  assert_mask_shape_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (lane_en_o[0] && ((lane_en_o & (lane_en_o + 1'b1)) == '0)));

  assert_idle_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> (lane_en_o == '0 && res_o == '0));

  assert_partial_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !lane_en_o[LANES-1]) |-> done_o);

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_fall_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
endmodule

bind vls_lane_seq vls_lane_seq_chk #(.LANES(LANES), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .elem_idx_o  (elem_idx_o),
  .res_valid_o (res_valid_o),
  .res_idx_o   (res_idx_o),
  .lane_en_o   (lane_en_o),
  .res_o       (res_o),
  .done_o      (done_o)
);

// File: tb/sim_vls_lane_seq.sv
module sim_vls_lane_seq;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned LANES   = 4;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned MAX_LEN = 31;
  localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1);
  localparam int unsigned MEM_N   = MAX_LEN + LANES + 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [LEN_W-1:0] vlen_i = '0;
  logic [2:0] opcode_i = '0;
  logic busy_o, res_valid_o, done_o;
  logic [LEN_W-1:0] elem_idx_o, res_idx_o;
  logic [LANES-1:0] lane_en_o;
  logic [LANES*DATA_W-1:0] a_bus, b_bus, res_o;

  logic [DATA_W-1:0] va [MEM_N];
  logic [DATA_W-1:0] vb [MEM_N];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vls_lane_seq #(.LANES(LANES), .DATA_W(DATA_W), .MAX_LEN(MAX_LEN)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .vlen_i(vlen_i),
    .opcode_i(opcode_i), .busy_o(busy_o), .elem_idx_o(elem_idx_o),
    .a_i(a_bus), .b_i(b_bus), .res_valid_o(res_valid_o), .res_idx_o(res_idx_o),
    .lane_en_o(lane_en_o), .res_o(res_o), .done_o(done_o)
  );

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      a_bus[l*DATA_W +: DATA_W] = va[int'(elem_idx_o) + l];
      b_bus[l*DATA_W +: DATA_W] = vb[int'(elem_idx_o) + l];
    end
  end

  function automatic logic [DATA_W-1:0] model(input logic [2:0] op, input logic [DATA_W-1:0] a, b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      default: return '0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // runs one vector; inject=1 pulses a conflicting start while busy (R7)
  task automatic run_vec(input int len, input logic [2:0] op, input bit inject);
    int base = 0;
    int passes = 0;
    bit seen_done = 0;
    for (int i = 0; i < MEM_N; i++) begin
      va[i] = $urandom;
      vb[i] = $urandom;
    end
    if (len == 2) begin va[0] = 32'hFFFF_FFFF; vb[0] = 32'h1; end
    @(negedge clk);
    start_i = 1'b1; vlen_i = LEN_W'(len); opcode_i = op;
    @(negedge clk);
    start_i = 1'b0;
    for (int cyc = 0; cyc < 20 && !seen_done; cyc++) begin
      if (inject && cyc == 0) begin start_i = 1'b1; vlen_i = LEN_W'(3); opcode_i = 3'd2; end
      if (inject && cyc == 1) start_i = 1'b0;
      if (res_valid_o) begin
        chk(res_idx_o == LEN_W'(base), "R1 res_idx", 64'(res_idx_o), 64'(base));
        for (int l = 0; l < LANES; l++) begin
          int e = base + l;
          bit en_x = (e < len);
          logic [DATA_W-1:0] y_x = en_x ? model(op, va[e], vb[e]) : '0;
          chk(lane_en_o[l] == en_x, "R4 lane_en", 64'(lane_en_o[l]), 64'(en_x));
          chk(res_o[l*DATA_W +: DATA_W] == y_x, (op > 3'd4) ? "R10 result" : "R2 result",
              64'(res_o[l*DATA_W +: DATA_W]), 64'(y_x));
        end
        base += LANES;
        passes++;
      end
      if (done_o) begin
        seen_done = 1;
        chk(!busy_o, "R8 busy low at done", 64'(busy_o), 64'd0);
        if (len > 0) chk(res_valid_o, "R8 done with final group", 64'(res_valid_o), 64'd1);
      end
      @(negedge clk);
    end
    chk(seen_done, "R8 done seen", 64'(seen_done), 64'd1);
    chk(passes == (len + LANES - 1) / LANES, (len == 0) ? "R6 no groups" : "R3 pass count",
        64'(passes), 64'((len + LANES - 1) / LANES));
    chk(!done_o && !res_valid_o, "R8 done single pulse", 64'({done_o, res_valid_o}), 64'd0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < MEM_N; i++) begin va[i] = '0; vb[i] = '0; end
    repeat (3) @(negedge clk);
    chk(!busy_o && !res_valid_o && !done_o && lane_en_o == '0 && res_o == '0, "R9 reset state",
        64'({busy_o, res_valid_o, done_o, lane_en_o}), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    // R5 scalar, R6 empty, R3 exact 16, R4 partial, R7 busy restart, R10 unused code
    run_vec(1, 3'd0, 0);
    run_vec(0, 3'd1, 0);
    run_vec(16, 3'd1, 0);
    run_vec(2, 3'd0, 0);
    run_vec(13, 3'd4, 1);
    run_vec(7, 3'd6, 0);
    run_vec(MAX_LEN, 3'd3, 0);
    for (int k = 0; k < 40; k++) run_vec(int'($urandom_range(0, MAX_LEN)), 3'($urandom_range(0, 4)), k[0]);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule